// File: doc/BRIEF.md
# UART Interrupt Source Prioritizer

This block gathers every interrupt condition of a UART channel, applies one enable bit per source, and presents a single active-high interrupt line together with a 6-bit identification field. The field describes only the most urgent enabled condition that is pending. Sources of lower rank stay hidden behind it until software has serviced everything above them.

Level sources are the line-status error, receive data ready, receive timeout and modem-status change. These come from their own registers and clear there. The block adds four sticky conditions of its own. The holding-register-empty condition is armed at reset and on every rising edge of the empty flag. The special-character match, the CTS change and the RTS change are held from a one-cycle pulse until software reads the identification field while that source is the one reported. A write to the holding register also withdraws the holding-register-empty condition.

The identification field and the interrupt line are combinational functions of the registered sticky state and the level inputs. A read strobe therefore takes effect from the cycle after the read.

Top module: `uart_irq_ident`

## Requirements
- R1: On the first cycle after reset is released, with `thr_empty`=1 and enable bit 1 set, `irq`=1 and `int_id`=0x02. With all enables clear, `int_id`=0x01.
- R2: `irq` is 1 exactly when at least one enabled source is pending.
- R3: When no enabled source is pending, `int_id`=0x01 and `irq`=0.
- R4: A line-status error (`line_err`, enable bit 2) outranks every other source and reports 0x06.
- R5: Receive data ready and receive timeout form one rank, both enabled by bit 0, and sit directly below line status. Data ready reports 0x04. Timeout reports 0x0C, but only when data ready is low.
- R6: Holding-register-empty (enable bit 1) ranks third and reports 0x02. A read strobe on `id_read` while 0x02 is shown clears it. The condition returns only when `thr_empty` next rises. `thr_write` also clears it.
- R7: A modem-status change (`modem_change`, enable bit 3) ranks fourth and reports 0x00.
- R8: A `spec_char` pulse latches a special-character condition (enable bit 5). It ranks fifth, reports 0x10 (bit 4 set) and stays until an `id_read` is made while 0x10 is shown. A read made while another code is shown leaves it pending.
- R9: A `cts_change` pulse (enable bit 6) or an `rts_change` pulse (enable bit 7) latches a flow-control condition. This condition ranks lowest and reports 0x20. It never shows while any higher enabled source is pending. An `id_read` made while 0x20 is shown clears both flow-control latches.
- R10: When a sticky condition is set and cleared in the same cycle, the set wins and the condition stays pending.
- R11: A source whose enable bit is clear changes neither `irq` nor `int_id`. Sticky sources still latch while disabled and appear once their enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier | input | 8 | Per-source enables (bit 4 unused) |
| line_err | input | 1 | Line-status error pending (level) |
| rx_ready | input | 1 | Receive data at trigger level (level) |
| rx_timeout | input | 1 | Receive timeout pending (level) |
| thr_empty | input | 1 | Transmit holding register empty (level) |
| thr_write | input | 1 | Strobe: holding register written |
| modem_change | input | 1 | Modem-status change pending (level) |
| spec_char | input | 1 | Pulse: special character matched |
| cts_change | input | 1 | Pulse: CTS flow-control change |
| rts_change | input | 1 | Pulse: RTS flow-control change |
| id_read | input | 1 | Strobe: identification field read |
| irq | output | 1 | Interrupt request |
| int_id | output | 6 | Identification code of the reported source |

## Verification
Two events can fall on the same edge: a read of the identification field that clears the reported sticky source, and a new pulse of that same source. The bench provokes this by driving `id_read` and `spec_char` together while 0x10 is shown. The condition must still read 0x10 on the next cycle, and a later lone read must bring the field to 0x01. A second overlap also appears: a read that clears holding-register-empty while the special-character condition waits beneath it. Here only 0x02 may disappear, and the field must fall through to 0x10.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int ID_W     = 6;
    localparam int IER_W    = 8;
    localparam int N_LEVELS = 6;
    localparam int LVL_W    = $clog2(N_LEVELS);
    localparam int N_EVENTS = 3;

    // enable bit positions
    localparam int EN_RX    = 0;
    localparam int EN_THR   = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;
    localparam int EN_SPEC  = 5;
    localparam int EN_CTS   = 6;
    localparam int EN_RTS   = 7;

    // sticky event slots
    localparam int EV_SPEC = 0;
    localparam int EV_CTS  = 1;
    localparam int EV_RTS  = 2;

    // identification codes
    localparam logic [ID_W-1:0] ID_NONE  = 6'h01;
    localparam logic [ID_W-1:0] ID_LINE  = 6'h06;
    localparam logic [ID_W-1:0] ID_RXDAT = 6'h04;
    localparam logic [ID_W-1:0] ID_RXTO  = 6'h0C;
    localparam logic [ID_W-1:0] ID_THR   = 6'h02;
    localparam logic [ID_W-1:0] ID_MODEM = 6'h00;
    localparam logic [ID_W-1:0] ID_SPEC  = 6'h10;
    localparam logic [ID_W-1:0] ID_FLOW  = 6'h20;

    // rank order, index 0 is most urgent
    typedef enum logic [LVL_W-1:0] {
        LV_LINE  = 3'd0,
        LV_RX    = 3'd1,
        LV_THR   = 3'd2,
        LV_MODEM = 3'd3,
        LV_SPEC  = 3'd4,
        LV_FLOW  = 3'd5
    } level_e;

    typedef struct packed {
        logic           any;
        level_e         level;
        logic [ID_W-1:0] code;
    } irq_report_t;

    function automatic logic [ID_W-1:0] level_code(input level_e lv, input logic rx_data);
        logic [ID_W-1:0] c;
        case (lv)
            LV_LINE:  c = ID_LINE;
            LV_RX:    c = rx_data ? ID_RXDAT : ID_RXTO;
            LV_THR:   c = ID_THR;
            LV_MODEM: c = ID_MODEM;
            LV_SPEC:  c = ID_SPEC;
            LV_FLOW:  c = ID_FLOW;
            default:  c = ID_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= RST_VAL;
        else if (set)
            q <= 1'b1;
        else if (clr)
            q <= 1'b0;
    end

    // R10: a set overrides a simultaneous clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        set |=> q);

    a_r10_clear_takes: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !q);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
    parameter int N = 6,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end

    // R2: the granted index is a live request and nothing more urgent is live
    a_r2_grant_valid: assert property (@(posedge clk) disable iff (rst)
        any |-> (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0)));

    a_r2_idle_no_req: assert property (@(posedge clk) disable iff (rst)
        !any |-> (req == '0));
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IER_W-1:0] ier,
    input  logic             line_err,
    input  logic             rx_ready,
    input  logic             rx_timeout,
    input  logic             thr_empty,
    input  logic             thr_write,
    input  logic             modem_change,
    input  logic             spec_char,
    input  logic             cts_change,
    input  logic             rts_change,
    input  logic             id_read,
    output logic             irq,
    output logic [ID_W-1:0]  int_id
);
    logic                thr_empty_q;
    logic                thr_rise;
    logic                thr_pend;
    logic                thr_clr;
    logic [N_EVENTS-1:0] ev_set;
    logic [N_EVENTS-1:0] ev_clr;
    logic [N_EVENTS-1:0] ev_pend;
    logic [N_LEVELS-1:0] lvl_req;
    logic                grant_any;
    logic [LVL_W-1:0]    grant_idx;
    level_e              grant_lvl;
    irq_report_t         rpt;
    logic                unused_ier4;
    logic                rst_q;

    assign unused_ier4 = ier[4];

    // holding-register-empty edge and sticky state
    always_ff @(posedge clk) begin
        if (rst) thr_empty_q <= 1'b1;
        else     thr_empty_q <= thr_empty;
    end

    assign thr_rise = thr_empty && !thr_empty_q;
    assign thr_clr  = thr_write || (id_read && grant_any && grant_lvl == LV_THR);

    uart_irq_sticky #(.RST_VAL(1'b1)) i_thr (
        .clk (clk),
        .rst (rst),
        .set (thr_rise),
        .clr (thr_clr),
        .q   (thr_pend)
    );

    // pulse-driven sticky events
    assign ev_set[EV_SPEC] = spec_char;
    assign ev_set[EV_CTS]  = cts_change;
    assign ev_set[EV_RTS]  = rts_change;

    assign ev_clr[EV_SPEC] = id_read && grant_any && grant_lvl == LV_SPEC;
    assign ev_clr[EV_CTS]  = id_read && grant_any && grant_lvl == LV_FLOW;
    assign ev_clr[EV_RTS]  = id_read && grant_any && grant_lvl == LV_FLOW;

    for (genvar g = 0; g < N_EVENTS; g++) begin : g_event
        uart_irq_sticky #(.RST_VAL(1'b0)) i_ev (
            .clk (clk),
            .rst (rst),
            .set (ev_set[g]),
            .clr (ev_clr[g]),
            .q   (ev_pend[g])
        );
    end

    // enabled request per rank
    always_comb begin
        lvl_req           = '0;
        lvl_req[LV_LINE]  = line_err && ier[EN_LINE];
        lvl_req[LV_RX]    = (rx_ready || rx_timeout) && ier[EN_RX];
        lvl_req[LV_THR]   = thr_pend && thr_empty && ier[EN_THR];
        lvl_req[LV_MODEM] = modem_change && ier[EN_MODEM];
        lvl_req[LV_SPEC]  = ev_pend[EV_SPEC] && ier[EN_SPEC];
        lvl_req[LV_FLOW]  = (ev_pend[EV_CTS] && ier[EN_CTS]) ||
                            (ev_pend[EV_RTS] && ier[EN_RTS]);
    end

    uart_irq_prio #(.N(N_LEVELS)) i_prio (
        .clk (clk),
        .rst (rst),
        .req (lvl_req),
        .any (grant_any),
        .idx (grant_idx)
    );

    assign grant_lvl = level_e'(grant_idx);

    always_comb begin
        rpt.any   = grant_any;
        rpt.level = grant_lvl;
        rpt.code  = grant_any ? level_code(grant_lvl, rx_ready) : ID_NONE;
    end

    assign irq    = rpt.any;
    assign int_id = rpt.code;

    // ---------------- assertions ----------------
    always_ff @(posedge clk) begin
        rst_q <= rst;
    end

    // R1: holding-register-empty is reported right after reset
    always_ff @(posedge clk) begin
        if (rst_q && !rst && thr_empty && ier[EN_THR] && !line_err &&
            !(ier[EN_RX] && (rx_ready || rx_timeout)))
            a_r1_thr_after_reset: assert (irq && int_id == ID_THR);
    end

    // R3: idle code whenever the line is low
    a_r3_idle_code: assert property (@(posedge clk) disable iff (rst)
        !irq |-> (int_id == ID_NONE));

    // R4: an enabled line error always wins
    a_r4_line_first: assert property (@(posedge clk) disable iff (rst)
        (line_err && ier[EN_LINE]) |-> (int_id == ID_LINE));

    // R9: flow-control code never shows over an enabled modem or line source
    a_r9_flow_lowest: assert property (@(posedge clk) disable iff (rst)
        ((line_err && ier[EN_LINE]) || (modem_change && ier[EN_MODEM])) |->
        (int_id != ID_FLOW));

    // R6: reading 0x02 withdraws it unless the empty flag rises again
    a_r6_thr_read_clears: assert property (@(posedge clk) disable iff (rst)
        (id_read && int_id == ID_THR && !thr_rise) |=> !thr_pend);
endmodule

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] ier;
    logic       line_err, rx_ready, rx_timeout, thr_empty, thr_write;
    logic       modem_change, spec_char, cts_change, rts_change, id_read;
    logic       irq;
    logic [5:0] int_id;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    uart_irq_ident i_uart_irq_ident (
        .clk(clk), .rst(rst), .ier(ier), .line_err(line_err), .rx_ready(rx_ready),
        .rx_timeout(rx_timeout), .thr_empty(thr_empty), .thr_write(thr_write),
        .modem_change(modem_change), .spec_char(spec_char), .cts_change(cts_change),
        .rts_change(rts_change), .id_read(id_read), .irq(irq), .int_id(int_id)
    );

    typedef struct packed {
        logic [7:0] ier;
        logic       ls;
        logic       rx;
        logic       to;
        logic       ms;
        logic       irq;
        logic [5:0] id;
        logic [3:0] req;
    } vec_t;

    // level-source table (sticky state clear, thr_empty held high)
    localparam vec_t VECS [10] = '{
        '{8'h0F, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 6'h06, 4'd4},  // R4
        '{8'h0F, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 6'h04, 4'd5},  // R5
        '{8'h0F, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 6'h0C, 4'd5},  // R5
        '{8'h0F, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 6'h00, 4'd7},  // R7
        '{8'h0F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h01, 4'd3},  // R3
        '{8'h0E, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 6'h01, 4'd11}, // R11
        '{8'h04, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 6'h06, 4'd4},  // R4
        '{8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 6'h01, 4'd11}, // R11
        '{8'h08, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'h00, 4'd11}, // R11
        '{8'h01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 6'h0C, 4'd5}   // R5
    };

    task automatic chk(input int req, input logic e_irq, input logic [5:0] e_id);
        checks++;
        if (irq !== e_irq || int_id !== e_id) begin
            errors++;
            $display("FAIL R%0d irq=%0d id=%h expected irq=%0d id=%h",
                     req, irq, int_id, e_irq, e_id);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_read();
        id_read = 1'b1; tick(); id_read = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ier = 8'h00;
        line_err = 0; rx_ready = 0; rx_timeout = 0; thr_empty = 1; thr_write = 0;
        modem_change = 0; spec_char = 0; cts_change = 0; rts_change = 0; id_read = 0;
        repeat (3) tick();
        rst = 1'b0;
        #1;
        chk(1, 1'b0, 6'h01);               // R1 / R3: all disabled after reset
        ier = 8'h02; #1;
        chk(1, 1'b1, 6'h02);               // R1: empty interrupt right away
        tick();
        pulse_read();
        chk(6, 1'b0, 6'h01);               // R6: read withdraws 0x02

        foreach (VECS[i]) begin
            ier = VECS[i].ier; line_err = VECS[i].ls; rx_ready = VECS[i].rx;
            rx_timeout = VECS[i].to; modem_change = VECS[i].ms;
            tick();
            chk(int'(VECS[i].req), VECS[i].irq, VECS[i].id); // R2 over all rows
        end
        line_err = 0; rx_ready = 0; rx_timeout = 0; modem_change = 0;

        // R6: re-armed only by a write then a new rise of the empty flag
        ier = 8'h02; tick();
        chk(6, 1'b0, 6'h01);
        thr_write = 1; thr_empty = 0; tick();
        thr_write = 0; tick();
        chk(6, 1'b0, 6'h01);
        thr_empty = 1; tick();
        chk(6, 1'b1, 6'h02);

        // R6 / R8: read of 0x02 leaves special character waiting below it
        ier = 8'h22;
        spec_char = 1; tick(); spec_char = 0;
        chk(6, 1'b1, 6'h02);
        pulse_read();
        chk(8, 1'b1, 6'h10);               // R8
        ier = 8'h24; line_err = 1; tick();
        chk(8, 1'b1, 6'h06);               // R8 masked by line status
        pulse_read();
        line_err = 0; ier = 8'h20; tick();
        chk(8, 1'b1, 6'h10);               // R8: read under 0x06 kept it
        pulse_read();
        chk(8, 1'b0, 6'h01);

        // R9: flow control is lowest and clears on its own read
        ier = 8'hC0;
        cts_change = 1; tick(); cts_change = 0;
        chk(9, 1'b1, 6'h20);
        ier = 8'hC8; modem_change = 1; tick();
        chk(9, 1'b1, 6'h00);
        modem_change = 0; tick();
        chk(9, 1'b1, 6'h20);
        rts_change = 1; tick(); rts_change = 0;
        pulse_read();
        chk(9, 1'b0, 6'h01);

        // R10: new event on the same edge as its clearing read
        ier = 8'h20;
        spec_char = 1; tick(); spec_char = 0;
        spec_char = 1; id_read = 1; tick(); spec_char = 0; id_read = 0;
        chk(10, 1'b1, 6'h10);
        pulse_read();
        chk(10, 1'b0, 6'h01);

        // R11: disabled sticky source still latches
        ier = 8'h00;
        cts_change = 1; tick(); cts_change = 0;
        chk(11, 1'b0, 6'h01);
        ier = 8'h40; #1;
        chk(11, 1'b1, 6'h20);
        tick();
        pulse_read();
        chk(11, 1'b0, 6'h01);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule